// File: doc/BRIEF.md
# Supply Droop Clock Throttle

This block guards a processor core against sudden sags on its supply rail. An on-chip supply monitor delivers digitized voltage samples, each marked by a valid strobe. The block compares every valid sample with a trip level derived from a programmable nominal voltage. When a sample lands below that level, the block throttles the core on the next clock edge. It does this by dropping a clock-enable output for one cycle in every fourteen, which cuts the effective clock rate by about 7%.

The throttle stays on until the rail has clearly recovered. A programmable number of consecutive valid samples must sit at or above the trip level plus a small hysteresis margin before the throttle releases. A status flag reports whether the throttle is engaged.

Top module: `droop_throttle`

## Requirements
- R1: After reset, and whenever reset is asserted, `droop_flag` is 0 and `core_clk_en` is 1.
- R2: The trip level is `nominal - floor(nominal/40)`. A valid sample strictly below the trip level engages the throttle at that clock edge, so `droop_flag` reads 1 in the following cycle.
- R3: A valid sample equal to or above the trip level does not engage the throttle.
- R4: Samples presented while `sample_valid` is 0 have no effect on the throttle.
- R5: While engaged, `core_clk_en` is 0 in the first engaged cycle and then in every 14th cycle after it. It is 1 in all other engaged cycles, giving exactly 2 low cycles in any 28 consecutive engaged cycles.
- R6: `droop_flag` is high exactly while the throttle is engaged, and `core_clk_en` is 1 whenever `droop_flag` is 0.
- R7: The throttle releases on the edge of the `release_samples`-th consecutive valid sample at or above trip level + HYST_LSB. The release level saturates at the all-ones code, and a `release_samples` value of 0 acts as 1.
- R8: While engaged, a valid sample below the release level restarts the count of qualifying samples from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Marks `sample` as a fresh monitor reading |
| sample | input | SAMPLE_W | Digitized supply voltage |
| nominal | input | SAMPLE_W | Programmed nominal supply code |
| release_samples | input | CNT_W | Consecutive good samples needed to release |
| core_clk_en | output | 1 | Clock enable for the core; 0 suppresses a cycle |
| droop_flag | output | 1 | High while the throttle is engaged |

## Verification
A wrong engage decision shows on `droop_flag` one cycle after the offending sample edge. A wrong phase counter shows as a misplaced or missing low pulse on `core_clk_en`, which becomes visible within 14 engaged cycles. A wrong recovery count shows as `droop_flag` falling one sample too early or too late. That error is therefore exposed by the sample that should or should not have released the throttle. Threshold arithmetic errors are exposed by samples placed exactly at and one code below the trip level, including a nominal value small enough that the 1/40 share rounds to zero.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic {
    ST_RUN      = 1'b0,
    ST_THROTTLE = 1'b1
  } thr_state_e;

  localparam int unsigned TRIP_DIVISOR = 40;
endpackage

// File: rtl/dt_droop_detect.sv
module dt_droop_detect #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned HYST_LSB = 8
) (
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] nominal,
  output logic                droop_hit,
  output logic                release_ok
);
  localparam logic [SAMPLE_W-1:0] DIV      = SAMPLE_W'(dt_pkg::TRIP_DIVISOR);
  localparam logic [SAMPLE_W:0]   HYST_EXT = (SAMPLE_W+1)'(HYST_LSB);

  // Trip level: nominal less its 1/40 share (about 2.5 %).
  function automatic logic [SAMPLE_W-1:0] trip_level(input logic [SAMPLE_W-1:0] nom);
    return nom - (nom / DIV);
  endfunction

  // Recovery level: trip plus hysteresis, clamped at full scale.
  function automatic logic [SAMPLE_W-1:0] recover_level(input logic [SAMPLE_W-1:0] trip);
    logic [SAMPLE_W:0] sum;
    sum = {1'b0, trip} + HYST_EXT;
    if (sum[SAMPLE_W]) return {SAMPLE_W{1'b1}};
    return sum[SAMPLE_W-1:0];
  endfunction

  logic [SAMPLE_W-1:0] trip_q;
  logic [SAMPLE_W-1:0] recover_q;

  always_comb begin
    trip_q     = trip_level(nominal);
    recover_q  = recover_level(trip_q);
    droop_hit  = sample_valid && (sample < trip_q);
    release_ok = sample_valid && (sample >= recover_q);
  end
endmodule

// File: rtl/dt_engage_ctrl.sv
module dt_engage_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic             droop_hit,
  input  logic             release_ok,
  input  logic [CNT_W-1:0] release_samples,
  output logic             engaged
);
  import dt_pkg::*;

  thr_state_e       state_q, state_d;
  logic [CNT_W-1:0] good_q, good_d;
  logic [CNT_W:0]   need;
  logic [CNT_W:0]   good_next;
  logic             release_now;

  always_comb begin
    need        = (release_samples == '0) ? (CNT_W+1)'(1) : {1'b0, release_samples};
    good_next   = {1'b0, good_q} + (CNT_W+1)'(1);
    release_now = (state_q == ST_THROTTLE) && release_ok && (good_next >= need);
    state_d     = state_q;
    good_d      = good_q;
    case (state_q)
      ST_RUN: begin
        good_d = '0;
        if (droop_hit) state_d = ST_THROTTLE;
      end
      default: begin
        if (release_now) begin
          state_d = ST_RUN;
          good_d  = '0;
        end else if (release_ok) begin
          good_d = good_next[CNT_W-1:0];
        end else if (sample_valid) begin
          good_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
    end
  end

  assign engaged = (state_q == ST_THROTTLE);

  // R2
  engage_on_droop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (droop_hit && !engaged) |=> engaged);
  // R4
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !engaged) |=> !engaged);
  // R7
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(engaged) |-> $past(release_ok));
  // R8
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && sample_valid && !release_ok) |=> (good_q == '0));
endmodule

// File: rtl/dt_clk_gate.sv
module dt_clk_gate #(
  parameter int unsigned PERIOD = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic engaged,
  output logic clk_en
);
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                phase_q <= '0;
    else if (!engaged)         phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                       phase_q <= phase_q + PH_W'(1);
  end

  assign clk_en = !(engaged && (phase_q == '0));

  // R5
  first_cycle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engaged) |-> !clk_en);
  // R5
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |=> clk_en);
  // R6
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |-> clk_en);
endmodule

// File: rtl/droop_throttle.sv
module droop_throttle #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned HYST_LSB = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned PERIOD   = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] nominal,
  input  logic [CNT_W-1:0]    release_samples,
  output logic                core_clk_en,
  output logic                droop_flag
);
  logic droop_hit;
  logic release_ok;
  logic engaged;

  dt_droop_detect #(.SAMPLE_W(SAMPLE_W), .HYST_LSB(HYST_LSB)) u_detect (
    .sample_valid (sample_valid),
    .sample       (sample),
    .nominal      (nominal),
    .droop_hit    (droop_hit),
    .release_ok   (release_ok)
  );

  dt_engage_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid    (sample_valid),
    .droop_hit       (droop_hit),
    .release_ok      (release_ok),
    .release_samples (release_samples),
    .engaged         (engaged)
  );

  dt_clk_gate #(.PERIOD(PERIOD)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .engaged (engaged),
    .clk_en  (core_clk_en)
  );

  assign droop_flag = engaged;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!droop_flag && core_clk_en));
endmodule

// File: tb/test_droop_throttle.sv
module test_droop_throttle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [11:0] sample = 12'd1000;
  logic [11:0] nominal = 12'd1000;
  logic [3:0]  release_samples = 4'd3;
  logic        core_clk_en;
  logic        droop_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  droop_throttle i_droop_throttle (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .nominal(nominal), .release_samples(release_samples),
    .core_clk_en(core_clk_en), .droop_flag(droop_flag)
  );

  function automatic int trip_of(int nom);
    return nom - (nom / 40);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic give_sample(int v);
    @(negedge clk);
    sample_valid = 1'b1;
    sample = v[11:0];
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 flag in reset", droop_flag, 0);
    chk("R1 enable in reset", core_clk_en, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_threshold_and_pattern();
    int lows;
    int t;
    nominal = 12'd1000;
    t = trip_of(1000);
    give_sample(t);
    chk("R3 sample at trip", droop_flag, 0);
    give_sample(t + 40);
    chk("R3 sample above trip", droop_flag, 0);
    give_sample(t - 1);
    chk("R2 engage below trip", droop_flag, 1);
    chk("R5 first engaged cycle dropped", core_clk_en, 0);
    lows = 1;
    for (int k = 1; k < 28; k++) begin
      @(negedge clk);
      if (!core_clk_en) lows++;
      if (k == 14) chk("R5 drop at cycle 14", core_clk_en, 0);
      if (k == 13) chk("R5 no drop at cycle 13", core_clk_en, 1);
    end
    chk("R5 drops in 28 cycles", lows, 2);
  endtask

  task automatic t_release();
    int rel;
    rel = trip_of(1000) + 8;
    release_samples = 4'd3;
    give_sample(rel);
    give_sample(rel);
    chk("R7 two good samples hold", droop_flag, 1);
    give_sample(rel - 1);
    chk("R8 bad sample holds", droop_flag, 1);
    give_sample(rel);
    give_sample(rel + 5);
    chk("R8 count restarted", droop_flag, 1);
    give_sample(1000);
    chk("R7 release on third", droop_flag, 0);
    chk("R6 enable after release", core_clk_en, 1);
  endtask

  task automatic t_ignore_invalid();
    @(negedge clk);
    sample_valid = 1'b0;
    sample = 12'd0;
    repeat (3) @(negedge clk);
    chk("R4 invalid low sample flag", droop_flag, 0);
    chk("R4 invalid low sample enable", core_clk_en, 1);
    sample = 12'd1000;
  endtask

  task automatic t_zero_release_and_small_nominal();
    nominal = 12'd30;
    release_samples = 4'd0;
    give_sample(30);
    chk("R2 small nominal at trip", droop_flag, 0);
    give_sample(29);
    chk("R2 small nominal below trip", droop_flag, 1);
    give_sample(38);
    chk("R7 zero count acts as one", droop_flag, 0);
  endtask

  task automatic t_reset_mid();
    nominal = 12'd1000;
    give_sample(10);
    chk("R2 deep droop engages", droop_flag, 1);
    do_reset();
    @(negedge clk);
    chk("R1 flag after reset", droop_flag, 0);
    chk("R6 enable after reset", core_clk_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flag at reset", droop_flag, 0);
    chk("R1 enable at reset", core_clk_en, 1);
    rst_n = 1'b1;
    t_threshold_and_pattern();
    t_release();
    t_ignore_invalid();
    t_zero_release_and_small_nominal();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule